// File: doc/BRIEF.md
# March Test Sequencer for Parallel Memory

This block exercises a word-wide parallel memory with a repeating march test and flags every word that reads back wrong. After a start pulse it first fills the whole memory with an alternating pattern, using ascending addresses. It then cycles without end through two passes. The first pass ascends, reading the fill pattern and writing its complement. The second pass descends, reading the complement and writing the fill pattern back. Each access goes through a request/ready handshake, so memories of any speed can be attached.

A failing read does not stop the test. The block pulses an error strobe for one clock and presents four values with it: the failing address, the data actually read, the march element in progress and the number of completed accesses. The write that belongs to that address follows straight away. A stop input returns the block to idle at any time. The error display and logging sit outside the block.

Top module: `march_tester`

## Requirements
- R1: While reset is asserted and after its release, until a start pulse arrives, `mem_req` and `err_valid` stay low.
- R2: A start pulse in idle begins element one. It writes the pattern A (0x55 for 8-bit data, alternating bits with bit 0 set) to every address from 0 up to the highest address, with `mem_we` high.
- R3: Element two visits the addresses from 0 up to the highest. At each address it first reads (`mem_we` low, expecting pattern A) and then writes pattern B, the complement of A (0xAA).
- R4: Element three visits the addresses from the highest down to 0. At each address it first reads (expecting B) and then writes A.
- R5: After element three finishes at address 0, the block goes back to element two at address 0, not to element one, and keeps alternating elements two and three until stopped.
- R6: An access completes on a rising edge at which `mem_req` and `mem_ready` are both high. Until then `mem_addr`, `mem_we` and `mem_wdata` are held unchanged. The next access is presented in the cycle that follows.
- R7: When a read completes and `mem_rdata` differs from the expected pattern, `err_valid` is high for exactly the next cycle. It comes with `err_addr` (the address), `err_data` (the value read), `err_phase` (2 for element two, 3 for element three) and `err_cycles`.
- R8: A mismatch does not halt the march. The next access is the write to the same address.
- R9: `stop` high at a rising edge returns the block to idle, and `mem_req` is low from the next cycle on. `start` has no effect while a test is running.
- R10: `err_cycles` is 48 bits wide. It reports the number of accesses completed since the last start, including the failing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a test from idle |
| stop | input | 1 | Abort and return to idle |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, sampled with ready |
| mem_ready | input | 1 | Access completes this edge |
| err_valid | output | 1 | One-cycle mismatch strobe |
| err_addr | output | AW | Failing address |
| err_data | output | DW | Data read at the failure |
| err_phase | output | 2 | March element of the failure |
| err_cycles | output | CW | Completed accesses at the failure |

## Verification
The bench drives `mem_ready` and `mem_rdata` on falling edges, so the design samples them at the next rising edge. The scoreboard compares the pending request at the falling edge where it grants ready. A read's error report is due one rising edge after the read completes, so the monitor checks for it at the very next falling edge and flags a strobe arriving at any other time. After `stop`, one rising edge must pass before `mem_req` is checked low. While an access is stalled, its request fields are compared against their values one falling edge earlier.

// File: rtl/march_tester.sv
module march_tester #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int CW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          err_valid,
  output logic [AW-1:0] err_addr,
  output logic [DW-1:0] err_data,
  output logic [1:0]    err_phase,
  output logic [CW-1:0] err_cycles
);
  localparam logic [1:0] IDLE = 2'd0, FILL = 2'd1, UP = 2'd2, DOWN = 2'd3;
  localparam logic [AW-1:0] LAST = {AW{1'b1}};
  localparam logic [DW-1:0] PAT_A = {(DW/2){2'b01}};
  localparam logic [DW-1:0] PAT_B = ~PAT_A;

  logic [1:0]    ph;
  logic          wr;
  logic [AW-1:0] addr;
  logic [CW-1:0] cyc;

  wire [DW-1:0] expect_rd = (ph == UP) ? PAT_A : PAT_B;
  wire          at_end    = (ph == DOWN) ? (addr == '0) : (addr == LAST);

  assign mem_req   = (ph != IDLE);
  assign mem_we    = wr;
  assign mem_addr  = addr;
  assign mem_wdata = (ph == UP) ? PAT_B : PAT_A;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= IDLE; wr <= 1'b1; addr <= '0; cyc <= '0;
      err_valid <= 1'b0; err_addr <= '0; err_data <= '0;
      err_phase <= IDLE; err_cycles <= '0;
    end else begin
      err_valid <= 1'b0;
      if (stop) begin
        ph <= IDLE;
      end else if (ph == IDLE) begin
        addr <= '0; wr <= 1'b1; cyc <= '0;
        if (start) ph <= FILL;
      end else if (mem_ready) begin
        cyc <= cyc + 1'b1;
        if (!wr) begin
          wr <= 1'b1;
          if (mem_rdata != expect_rd) begin
            err_valid  <= 1'b1;
            err_addr   <= addr;
            err_data   <= mem_rdata;
            err_phase  <= ph;
            err_cycles <= cyc + 1'b1;
          end
        end else begin
          case (ph)
            FILL: begin
              if (at_end) begin ph <= UP; addr <= '0; wr <= 1'b0; end
              else addr <= addr + 1'b1;
            end
            UP: begin
              wr <= 1'b0;
              if (at_end) ph <= DOWN;
              else addr <= addr + 1'b1;
            end
            default: begin
              wr <= 1'b0;
              if (at_end) ph <= UP;
              else addr <= addr - 1'b1;
            end
          endcase
        end
      end
    end
  end

  p_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !stop) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !stop) |=> (cyc == $past(cyc) + 1'b1));

  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> !err_valid);

  p_err_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> err_phase[1]);

  p_fill_writes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && ph == FILL) |-> (mem_we && mem_wdata == PAT_A));

  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !mem_req);

  p_down_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == DOWN && mem_ready && wr && !stop && addr != '0) |=> (mem_addr == $past(mem_addr) - 1'b1));

  p_after_err_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (mem_we && mem_addr == err_addr));
endmodule

// File: tb/march_tester_bench.sv
`timescale 1ns/1ps
module march_tester_bench;
  localparam int AW = 4, DW = 8, CW = 48, N = 16;
  localparam logic [DW-1:0] PA = 8'h55, PB = 8'hAA;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, stop = 1'b0;
  logic mem_req, mem_we, mem_ready = 1'b0, err_valid;
  logic [AW-1:0] mem_addr, err_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0, err_data;
  logic [1:0] err_phase;
  logic [CW-1:0] err_cycles;

  march_tester #(.AW(AW), .DW(DW), .CW(CW)) u_march_tester (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .err_valid(err_valid), .err_addr(err_addr), .err_data(err_data),
    .err_phase(err_phase), .err_cycles(err_cycles));

  typedef struct packed { logic we; logic lp; logic [1:0] ph; logic [AW-1:0] a; logic [DW-1:0] d; } item_t;
  item_t q[$];

  int passed = 0, total = 0, errs_seen = 0;
  logic [DW-1:0] mem [N];
  logic [DW-1:0] fmask [N];

  task automatic chk(input bit ok, input string msg);
    total++;
    if (ok) passed++;
    else $display("FAIL %s", msg);
  endtask

  task automatic push_march(input int passes);
    for (int a = 0; a < N; a++) q.push_back({1'b1, 1'b0, 2'd1, AW'(a), PA});
    for (int p = 0; p < passes; p++) begin
      for (int a = 0; a < N; a++) begin
        q.push_back({1'b0, p > 0, 2'd2, AW'(a), PA});
        q.push_back({1'b1, p > 0, 2'd2, AW'(a), PB});
      end
      for (int a = N - 1; a >= 0; a--) begin
        q.push_back({1'b0, p > 0, 2'd3, AW'(a), PB});
        q.push_back({1'b1, p > 0, 2'd3, AW'(a), PA});
      end
    end
  endtask

  function automatic string tag_of(item_t it);
    string t;
    t = (it.ph == 2'd1) ? "R2" : (it.ph == 2'd2) ? "R3" : "R4";
    if (it.lp) t = {t, " R5"};
    if (it.we && it.ph != 2'd1) t = {t, " R8"};
    return t;
  endfunction

  // memory model, scoreboard monitor and error monitor
  int waitc = 0, acc = 0;
  bit pend_v = 0, stall = 0;
  logic [AW-1:0] pa, s_a;
  logic [DW-1:0] pd, s_d;
  logic [1:0] pp;
  logic s_we;
  int pc;
  always @(negedge clk) begin
    item_t it;
    logic [DW-1:0] rd;
    if (pend_v) begin
      errs_seen++;
      chk(err_valid && err_addr == pa && err_data == pd && err_phase == pp && err_cycles == CW'(pc),
          $sformatf("R7 R10 error report: v=%0b a=%0d d=%h ph=%0d cyc=%0d exp a=%0d d=%h ph=%0d cyc=%0d",
                    err_valid, err_addr, err_data, err_phase, err_cycles, pa, pd, pp, pc));
    end else if (err_valid) begin
      chk(1'b0, $sformatf("R7 unexpected strobe: err_valid=1 a=%0d exp err_valid=0", err_addr));
    end
    pend_v = 0;
    if (start && !mem_req) acc = 0;
    if (mem_req && stall)
      chk(mem_addr == s_a && mem_we == s_we && mem_wdata == s_d,
          $sformatf("R6 held fields: a=%0d we=%0b d=%h exp a=%0d we=%0b d=%h",
                    mem_addr, mem_we, mem_wdata, s_a, s_we, s_d));
    stall = 0;
    mem_ready = 1'b0;
    if (mem_req && q.size() > 0) begin
      if (waitc > 0) begin
        waitc--;
        stall = 1; s_a = mem_addr; s_we = mem_we; s_d = mem_wdata;
      end else begin
        it = q.pop_front();
        acc++;
        chk(mem_we == it.we && mem_addr == it.a && (!it.we || mem_wdata == it.d),
            $sformatf("%s access: we=%0b a=%0d d=%h exp we=%0b a=%0d d=%h",
                      tag_of(it), mem_we, mem_addr, mem_wdata, it.we, it.a, it.d));
        if (mem_we) mem[mem_addr] = mem_wdata;
        else begin
          rd = mem[mem_addr] ^ fmask[mem_addr];
          mem_rdata = rd;
          if (rd != it.d) begin
            pend_v = 1; pa = mem_addr; pd = rd; pp = it.ph; pc = acc;
          end
        end
        mem_ready = 1'b1;
        waitc = acc % 3;
      end
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  endtask

  task automatic pulse(ref logic sig);
    @(posedge clk); #1 sig = 1'b1;
    @(posedge clk); #1 sig = 1'b0;
  endtask

  task automatic run_session(input int passes, input bit poke_start);
    push_march(passes);
    pulse(start);
    if (poke_start) begin
      repeat (100) @(posedge clk);
      pulse(start);   // R9: must be ignored while running
    end
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(posedge clk);
    #1 stop = 1'b1;
    @(posedge clk); #1 stop = 1'b0;
    @(negedge clk);
    chk(!mem_req, $sformatf("R9 stop: mem_req=%0b exp 0", mem_req));
    repeat (4) @(negedge clk);
    chk(!mem_req, $sformatf("R9 stays idle: mem_req=%0b exp 0", mem_req));
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin fmask[i] = '0; end
    repeat (3) @(negedge clk);
    chk(!mem_req && !err_valid, $sformatf("R1 in reset: req=%0b err=%0b exp 0 0", mem_req, err_valid));
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mem_req && !err_valid, $sformatf("R1 after reset: req=%0b err=%0b exp 0 0", mem_req, err_valid));
    chk($bits(err_cycles) == 48, $sformatf("R10 width: %0d exp 48", $bits(err_cycles)));

    run_session(2, 1'b0);
    chk(errs_seen == 0, $sformatf("R7 clean run errors: %0d exp 0", errs_seen));

    fmask[5] = 8'h01;
    run_session(2, 1'b1);
    chk(errs_seen == 4, $sformatf("R7 R8 faulty word errors: %0d exp 4", errs_seen));

    fmask[5] = 8'h00; fmask[0] = 8'h80; fmask[N-1] = 8'hFF;
    run_session(1, 1'b0);
    chk(errs_seen == 8, $sformatf("R7 boundary errors: %0d exp 8", errs_seen));

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    $display("FAIL watchdog expired: queue=%0d exp 0", q.size());
    finish_run();
  end
endmodule